// File: doc/BRIEF.md
# Event Interrupt Aggregator with Pulse Mode

This block gathers single-cycle event strobes that a USB device core raises (bus reset, resume, suspend change, DMA transfer end, frame markers, control OUT endpoint) and holds each one in a sticky status bit until software clears it. A per-bit enable mask chooses which status bits may drive the interrupt pin. A global enable can mask all of them at once. Software reaches every register through a small synchronous register port. Reads are combinational. Writes take effect at the clock edge.

The interrupt pin has two signalling modes. In level mode it stays active while any enabled status bit is set. In pulse mode it gives one pulse of `PULSE_CYCLES` clocks each time the combined condition goes from false to true. It gives no further pulse until the condition has dropped and risen again. A polarity control selects whether the active level is high or low. After reset the pin is active-low in level mode.

Register map (2-bit address): 0 = status (read; writing 1 clears a bit), 1 = enable mask, 2 = control, 3 = reads zero and ignores writes. Control bits are: bit 0 global enable, bit 1 active-high polarity, bit 2 pulse mode.

Status bit map:

| Bit | Meaning |
|-----|---------|
| 0 | Bus reset |
| 1 | Resume |
| 2 | Suspend change |
| 3 | DMA end |
| 4 | Frame start |
| 5 | Pseudo frame tick |
| 6 | Reserved, always reads 0 |
| 7 | Live bus state (1 = suspended) |
| 8 | Control OUT endpoint |

Top module: `evt_irq_hub`

## Requirements
- R1: After reset the latched status bits, the enable mask and all control bits are 0, so the pin `irq_pin` is high: it is active-low, in level mode and inactive.
- R2: A strobe on `evt_strobe` bit 0, 1, 2, 3, 4, 5 or 8 sets the matching status bit at that clock edge. The bit stays set until it is cleared.
- R3: A write to address 0 clears each latched status bit whose write-data bit is 1. It leaves every bit written with 0 unchanged.
- R4: When a strobe and a clear for the same status bit arrive in the same cycle, the bit ends up set.
- R5: Status bit 7 always shows the live `bus_suspended` input. Status bit 6 always reads 0. Strobes on bits 6 and 7 have no effect.
- R6: A status bit contributes to the interrupt condition only when its bit in the enable mask (address 1) is 1. An enabled bit 7 contributes its live value.
- R7: While control bit 0 (global enable) is 0, no status bit contributes to the interrupt condition.
- R8: In level mode (control bit 2 = 0), the pin is active in every cycle in which the interrupt condition holds. It is inactive in every other cycle.
- R9: In pulse mode (control bit 2 = 1), a 0-to-1 change of the interrupt condition makes the pin active for exactly `PULSE_CYCLES` clocks (default 8). The pulse starts one clock after the condition becomes visible.
- R10: In pulse mode, no new pulse starts while the condition stays true. A new pulse starts after the condition drops and rises again.
- R11: With control bit 1 = 1 the pin is active-high; with 0 it is active-low. The inactive level is always the inverse. A polarity write shows on the pin right after the writing clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 9 | Single-cycle event strobes, one per status bit |
| bus_suspended | input | 1 | Live bus state, 1 = suspended |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_pin | output | 1 | Interrupt output |

## Verification
Every cycle, the assertions check the following:
- Strobes set their status bits, cleared bits drop, and untouched bits stay put.
- The pulse counter loads only on a rising condition in pulse mode, counts down one per clock, and never restarts on its own.
- In level mode the pin is inactive whenever the condition is false.

Only the bench's scenarios show the rest:
- The full bit map, including the reserved bit and the live bus-state bit.
- The exact pulse width and its start cycle.
- The absence of a retrigger while the condition stays high.
- The polarity change on the pin.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int SRC_N    = 9;
  localparam int BIT_RSVD = 6;
  localparam int BIT_BUS  = 7;
  localparam int CTRL_W   = 3;
  localparam int C_GIE    = 0;
  localparam int C_POL    = 1;
  localparam int C_PULSE  = 2;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_ENABLE = 2'd1,
    A_CTRL   = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;

  // Bits that latch events; reserved and live bus-state bits excluded.
  function automatic logic [SRC_N-1:0] latch_mask();
    logic [SRC_N-1:0] m;
    m = '1;
    m[BIT_RSVD] = 1'b0;
    m[BIT_BUS]  = 1'b0;
    return m;
  endfunction

  // Next latched value: clear first, then events win.
  function automatic logic [SRC_N-1:0] next_latch(input logic [SRC_N-1:0] cur,
                                                  input logic [SRC_N-1:0] evt,
                                                  input logic [SRC_N-1:0] clr);
    return ((cur & ~clr) | evt) & latch_mask();
  endfunction
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import evt_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt_in,
  input  logic [SRC_N-1:0] clr_in,
  input  logic             bus_live,
  output logic [SRC_N-1:0] status_view
);
  logic [SRC_N-1:0] latched_q;
  logic [SRC_N-1:0] set_req;

  assign set_req = evt_in & latch_mask();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latched_q <= '0;
    else        latched_q <= next_latch(latched_q, evt_in, clr_in);
  end

  always_comb begin
    status_view = latched_q;
    status_view[BIT_BUS] = bus_live;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((latched_q & $past(set_req)) == $past(set_req)));

  // R3 and R4: cleared bits drop unless an event hits them the same cycle.
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_in & ~set_req) != '0) |=> ((latched_q & $past(clr_in & ~set_req)) == '0));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latched_q & $past(latched_q & ~clr_in)) == $past(latched_q & ~clr_in)));
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SRC_N-1:0]  status_view,
  output logic [DATA_W-1:0] rdata,
  output logic [SRC_N-1:0]  clr_bits,
  output logic [SRC_N-1:0]  enable_q,
  output logic              gie_q,
  output logic              pol_high_q,
  output logic              pulse_q
);
  reg_addr_e a;
  assign a = reg_addr_e'(addr);

  assign clr_bits = (wr && a == A_STATUS) ? wdata[SRC_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= '0;
      gie_q      <= 1'b0;
      pol_high_q <= 1'b0;
      pulse_q    <= 1'b0;
    end else if (wr) begin
      if (a == A_ENABLE) enable_q <= wdata[SRC_N-1:0];
      if (a == A_CTRL) begin
        gie_q      <= wdata[C_GIE];
        pol_high_q <= wdata[C_POL];
        pulse_q    <= wdata[C_PULSE];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (a)
      A_STATUS: rdata[SRC_N-1:0] = status_view;
      A_ENABLE: rdata[SRC_N-1:0] = enable_q;
      A_CTRL:   rdata[CTRL_W-1:0] = {pulse_q, pol_high_q, gie_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_pin.sv
module evt_irq_pin #(
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic pulse_mode,
  input  logic pol_high,
  output logic rise,
  output logic active,
  output logic pin
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic          cond_d;
  logic [CW-1:0] cnt_q;

  assign rise = cond && !cond_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_d <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cond_d <= cond;
      if (!pulse_mode)        cnt_q <= '0;
      else if (rise)          cnt_q <= LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = pulse_mode ? (cnt_q != '0) : cond;
  assign pin    = pol_high ? active : !active;

  assert_pulse_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && rise) |=> (cnt_q == LOAD));

  assert_pulse_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !rise && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !(pulse_mode && rise)) |=> (cnt_q == '0));
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int PULSE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_strobe,
  input  logic              bus_suspended,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pin
);
  logic [SRC_N-1:0] status_view, clr_bits, enable_q;
  logic gie_q, pol_high_q, pulse_q;
  logic irq_cond, irq_rise, irq_active;

  evt_status_bank u_status (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_strobe), .clr_in(clr_bits),
    .bus_live(bus_suspended), .status_view(status_view)
  );

  evt_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status_view(status_view), .rdata(reg_rdata), .clr_bits(clr_bits),
    .enable_q(enable_q), .gie_q(gie_q), .pol_high_q(pol_high_q), .pulse_q(pulse_q)
  );

  assign irq_cond = gie_q && ((status_view & enable_q) != '0);

  evt_irq_pin #(.PULSE_CYCLES(PULSE_CYCLES)) u_pin (
    .clk(clk), .rst_n(rst_n), .cond(irq_cond), .pulse_mode(pulse_q),
    .pol_high(pol_high_q), .rise(irq_rise), .active(irq_active), .pin(irq_pin)
  );

  assert_level_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_q && !irq_cond) |-> (irq_pin == !pol_high_q));

  assert_gie_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_rise);
endmodule

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] evt_strobe = '0;
  logic bus_suspended = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_pin;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_hub #(.DATA_W(DW), .PULSE_CYCLES(PW)) uut (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .bus_suspended(bus_suspended),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pin(irq_pin)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe(input logic [8:0] m);
    evt_strobe = m;
    @(negedge clk);
    evt_strobe = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Expected pin level from the polarity and whether the pin should be active.
  function automatic logic pin_exp(input logic pol_high, input logic act);
    return pol_high ? act : ~act;
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(2'd0, v); check("R1 status", v, 16'h0);
    rd(2'd1, v); check("R1 enable", v, 16'h0);
    rd(2'd2, v); check("R1 ctrl", v, 16'h0);
    check("R1 pin", {15'd0, irq_pin}, 16'h1);

    // R2/R5: sweep every strobe bit singly
    for (int i = 0; i < 9; i++) begin
      logic [DW-1:0] exp;
      strobe(9'(1 << i));
      exp = (i == 6 || i == 7) ? 16'h0 : 16'(1 << i);
      rd(2'd0, v); check((i == 6 || i == 7) ? "R5 ignored strobe" : "R2 set", v, exp);
      wr(2'd0, 16'h1FF);
    end

    // R2: sticky across cycles
    strobe(9'h109);
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R2 sticky", v, 16'h109);

    // R3: write-1 clears, write-0 keeps
    wr(2'd0, 16'h001);
    rd(2'd0, v); check("R3 partial clear", v, 16'h108);
    wr(2'd0, 16'h000);
    rd(2'd0, v); check("R3 zero write", v, 16'h108);
    wr(2'd0, 16'h1FF);
    rd(2'd0, v); check("R3 full clear", v, 16'h0);

    // R4: event wins over simultaneous clear
    strobe(9'h004);
    evt_strobe = 9'h004; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h004;
    @(negedge clk);
    evt_strobe = '0; reg_wr = 1'b0;
    rd(2'd0, v); check("R4 event wins", v, 16'h004);
    wr(2'd0, 16'h1FF);

    // R5: live bus bit, address 3 reads zero
    bus_suspended = 1'b1;
    rd(2'd0, v); check("R5 bus live high", v, 16'h080);
    bus_suspended = 1'b0;
    rd(2'd0, v); check("R5 bus live low", v, 16'h000);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); check("R5 unused addr", v, 16'h0);

    // R7: global enable off masks everything
    wr(2'd1, 16'h1FF);
    strobe(9'h001);
    check("R7 gie off", {15'd0, irq_pin}, 16'h1);

    // R8: level mode active while pending
    wr(2'd2, 16'h001);
    check("R8 level active", {15'd0, irq_pin}, {15'd0, pin_exp(1'b0, 1'b1)});

    // R11: polarity switch takes effect right after the write
    wr(2'd2, 16'h003);
    check("R11 active high", {15'd0, irq_pin}, {15'd0, pin_exp(1'b1, 1'b1)});
    wr(2'd0, 16'h1FF);
    check("R11 inactive high pol", {15'd0, irq_pin}, {15'd0, pin_exp(1'b1, 1'b0)});
    wr(2'd2, 16'h001);
    check("R8 level idle", {15'd0, irq_pin}, 16'h1);

    // R6: per-bit enable sweep
    for (int i = 0; i < 9; i++) begin
      if (i == 6 || i == 7) continue;
      wr(2'd1, 16'h1FF & ~16'(1 << i));
      strobe(9'(1 << i));
      check("R6 masked bit", {15'd0, irq_pin}, 16'h1);
      wr(2'd1, 16'(1 << i));
      check("R6 enabled bit", {15'd0, irq_pin}, 16'h0);
      wr(2'd0, 16'h1FF);
    end
    wr(2'd1, 16'h080);
    bus_suspended = 1'b1; #1;
    check("R6 live bus contributes", {15'd0, irq_pin}, 16'h0);
    bus_suspended = 1'b0; #1;
    check("R6 live bus drops", {15'd0, irq_pin}, 16'h1);

    // R9: pulse width, active-low
    wr(2'd1, 16'h003);
    wr(2'd2, 16'h005);
    strobe(9'h001);
    check("R9 pulse not yet", {15'd0, irq_pin}, 16'h1);
    for (int k = 0; k < PW; k++) begin
      @(negedge clk);
      check("R9 pulse active", {15'd0, irq_pin}, 16'h0);
    end
    @(negedge clk);
    check("R9 pulse ended", {15'd0, irq_pin}, 16'h1);

    // R10: no retrigger while condition stays high
    strobe(9'h002);
    for (int k = 0; k < PW + 2; k++) begin
      check("R10 no retrigger", {15'd0, irq_pin}, 16'h1);
      @(negedge clk);
    end
    wr(2'd0, 16'h1FF);
    @(negedge clk);
    check("R10 idle after clear", {15'd0, irq_pin}, 16'h1);

    // R10/R11: new pulse after drop and rise, active-high
    wr(2'd2, 16'h007);
    strobe(9'h002);
    check("R11 pulse pending low", {15'd0, irq_pin}, 16'h0);
    for (int k = 0; k < PW; k++) begin
      @(negedge clk);
      check("R10 repeat pulse", {15'd0, irq_pin}, 16'h1);
    end
    @(negedge clk);
    check("R9 repeat pulse ended", {15'd0, irq_pin}, 16'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule